// File: doc/BRIEF.md
# Serial-Controlled Converter Sequencer

This block is the digital control core of a multichannel 8-bit converter that a host drives over a four-wire serial port. The port has an active-low select, a serial address line, an I/O clock and a free-running conversion clock. One 8-clock exchange does two jobs. It shifts out the result of the last finished conversion, and it shifts in the 5-bit channel number for the next one. After the exchange, the block holds a sample of the addressed channel and times a fixed-length conversion. At the end of that conversion the result becomes the stored value that the next exchange reads.

All four port inputs are asynchronous to the core clock. Each is resynchronised and, for the two clocks, edge-detected. The core clock must therefore run several times faster than either external clock. Select changes are filtered against the conversion clock before they take effect. The analog side is represented by a parallel `sample_in` bus. The block captures it at the instant sampling ends and publishes it as the result once the conversion count has elapsed. A new exchange during a conversion, or a fresh select, abandons the running conversion. The stored result is never overwritten by an abandoned conversion.

Top module: `adc_serial_seq`

## Requirements
- R1: A level change on `sel_n` is acted on only after two rising edges and then one falling edge of `sys_clk` have been seen, all while the changed level persists. A pulse shorter than that leaves the selected state untouched.
- R2: While deselected, `ser_dout_en` is 0 and `ser_dout` is driven 0. Edges on `io_clk` and values on `ser_addr` are ignored, so `chan_sel` and `sampling` do not change.
- R3: When select is recognised low, `ser_dout` shows the MSB of the stored result before any `io_clk` edge.
- R4: The channel number is 5 bits wide and positive logic. It is taken MSB first from `ser_addr` on `io_clk` rising edges 1 to 5 of the exchange, and appears on `chan_sel` at falling edge 5.
- R5: `io_clk` falling edges 1 to 7 move `ser_dout` to stored-result bits 6 down to 0 (bit 7 is the MSB).
- R6: `sampling` goes high at falling edge 5 and low at falling edge 8.
- R7: At falling edge 8, `sample_in` is captured and `busy` goes high. After 36 further `sys_clk` rising edges, the captured value becomes the stored result and `busy` goes low. The stored result changes at no other time.
- R8: A complete new exchange while `busy` restarts the count with the new sample. The abandoned conversion never reaches the stored result, and that exchange reads the previous stored result.
- R9: A conversion continues while deselected. A recognised select (high to low) during `busy` aborts it, clears `busy` and keeps the stored result.
- R10: A channel number of 19 or above completes the exchange normally, but sets `addr_oor` and forces `chan_sel` to 0. A number from 0 to 18 clears `addr_oor` and is shown as is.
- R11: `ser_dout` shows the MSB of the new result when a conversion completes while selected with no exchange under way. After falling edge 8, it shows the MSB of the stored result.
- R12: After reset, `ser_dout_en`, `ser_dout`, `busy`, `sampling`, `addr_oor` and `chan_sel` are all 0, and the stored result is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; all logic is synchronous to it |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Active-low select from the host, asynchronous |
| ser_addr | input | 1 | Serial channel number, MSB first, asynchronous |
| io_clk | input | 1 | Exchange clock from the host, asynchronous |
| sys_clk | input | 1 | Free-running conversion clock, asynchronous |
| sample_in | input | DATA_W | Parallel value standing for the analog input |
| ser_dout | output | 1 | Serial result bit |
| ser_dout_en | output | 1 | High when the result line would be driven |
| chan_sel | output | ADDR_W | Channel being sampled |
| addr_oor | output | 1 | Last channel number was out of range |
| sampling | output | 1 | Sample phase in progress |
| busy | output | 1 | Conversion in progress |

## Verification
The hardest states to reach from the ports are those where a conversion is cut short. One is a second full exchange that lands inside the 36-cycle window. The other is a deselect followed by a reselect before the count ends. The stimulus reaches the first by running two exchanges back to back with different `sample_in` values, then reading the result after the window has closed. It reaches the second by dropping and restoring select within about a hundred core cycles of the hold instant. A select pulse shorter than two conversion-clock periods checks that the filter does not let the block resynchronise by mistake. A cycle-accurate behavioural model then compares every output on every clock.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int DEF_DATA_W      = 8;
  localparam int DEF_ADDR_W      = 5;
  localparam int DEF_NUM_CH      = 19;
  localparam int DEF_CONV_CYCLES = 36;
  localparam int DEF_SYNC_STAGES = 2;

  // progress of the select qualifier after a level change
  typedef enum logic [1:0] {
    QW_IDLE  = 2'd0,
    QW_RISE1 = 2'd1,
    QW_RISE2 = 2'd2
  } qual_state_t;
endpackage

// File: rtl/adc_sync.sv
module adc_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);
  logic [W-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= din;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= RST_VAL;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  assign q = pipe[STAGES-1];
endmodule

// File: rtl/adc_cs_qual.sv
module adc_cs_qual
  import adc_seq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic cs_lvl,
  input  logic sys_rise,
  input  logic sys_fall,
  output logic cs_rec,
  output logic sel_fall,
  output logic sel_rise
);
  qual_state_t state;
  logic pending, accept;

  assign pending  = (cs_lvl != cs_rec);
  assign accept   = pending && (state == QW_RISE2) && sys_fall;
  assign sel_fall = accept && !cs_lvl;
  assign sel_rise = accept && cs_lvl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= QW_IDLE;
      cs_rec <= 1'b1;
    end else if (!pending) begin
      state <= QW_IDLE;
    end else if (accept) begin
      state  <= QW_IDLE;
      cs_rec <= cs_lvl;
    end else if (sys_rise) begin
      state <= (state == QW_IDLE) ? QW_RISE1 : QW_RISE2;
    end
  end
endmodule

// File: rtl/adc_conv.sv
module adc_conv #(
  parameter int DATA_W = 8,
  parameter int CONV_CYCLES = 36
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              abort,
  input  logic              sys_rise,
  input  logic [DATA_W-1:0] sample_in,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] held,
  output logic [DATA_W-1:0] result
);
  localparam int CNT_W = (CONV_CYCLES > 1) ? $clog2(CONV_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(CONV_CYCLES - 1);

  logic [CNT_W-1:0] cnt;

  assign done = busy && sys_rise && (cnt == LAST_CNT) && !start && !abort;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      cnt    <= '0;
      held   <= '0;
      result <= '0;
    end else if (start) begin
      held <= sample_in;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (abort) begin
      busy <= 1'b0;
    end else if (busy && sys_rise) begin
      if (cnt == LAST_CNT) begin
        busy   <= 1'b0;
        result <= held;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_xfer.sv
module adc_xfer #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5,
  parameter int NUM_CH = 19
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              sel_fall,
  input  logic              sel_rise,
  input  logic              io_rise,
  input  logic              io_fall,
  input  logic              addr_bit,
  input  logic [DATA_W-1:0] result,
  input  logic [DATA_W-1:0] held,
  input  logic              conv_done,
  output logic              out_bit,
  output logic [ADDR_W-1:0] chan_sel,
  output logic              addr_oor,
  output logic              sampling,
  output logic              hold_pulse
);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [BIT_W-1:0]  LAST_BIT = BIT_W'(DATA_W - 1);
  localparam logic [BIT_W-1:0]  ADDR_END = BIT_W'(ADDR_W);
  localparam logic [BIT_W-1:0]  SAMP_BIT = BIT_W'(ADDR_W - 1);
  localparam logic [ADDR_W-1:0] CH_LIMIT = ADDR_W'(NUM_CH);

  logic [BIT_W-1:0]  bitcnt;
  logic [ADDR_W-1:0] addr_sr;
  logic [DATA_W-1:0] shreg;
  logic              io_ok;

  assign io_ok      = active && !sel_fall && !sel_rise;
  assign hold_pulse = io_ok && io_fall && (bitcnt == LAST_BIT);
  assign out_bit    = shreg[DATA_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bitcnt   <= '0;
      addr_sr  <= '0;
      shreg    <= '0;
      chan_sel <= '0;
      addr_oor <= 1'b0;
      sampling <= 1'b0;
    end else if (sel_fall) begin
      bitcnt   <= '0;
      shreg    <= result;
      sampling <= 1'b0;
    end else if (sel_rise) begin
      bitcnt   <= '0;
      sampling <= 1'b0;
    end else if (active) begin
      if (io_rise && (bitcnt < ADDR_END))
        addr_sr <= {addr_sr[ADDR_W-2:0], addr_bit};
      if (io_fall) begin
        if (bitcnt == LAST_BIT) begin
          bitcnt   <= '0;
          sampling <= 1'b0;
          shreg    <= result;
        end else begin
          bitcnt <= bitcnt + 1'b1;
          shreg  <= {shreg[DATA_W-2:0], 1'b0};
          if (bitcnt == SAMP_BIT) begin
            sampling <= 1'b1;
            if (addr_sr < CH_LIMIT) begin
              chan_sel <= addr_sr;
              addr_oor <= 1'b0;
            end else begin
              chan_sel <= '0;
              addr_oor <= 1'b1;
            end
          end
        end
      end else if (conv_done && (bitcnt == '0)) begin
        shreg <= held;
      end
    end
  end
endmodule

// File: rtl/adc_serial_seq.sv
module adc_serial_seq
  import adc_seq_pkg::*;
#(
  parameter int DATA_W      = DEF_DATA_W,
  parameter int ADDR_W      = DEF_ADDR_W,
  parameter int NUM_CH      = DEF_NUM_CH,
  parameter int CONV_CYCLES = DEF_CONV_CYCLES,
  parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_n,
  input  logic              ser_addr,
  input  logic              io_clk,
  input  logic              sys_clk,
  input  logic [DATA_W-1:0] sample_in,
  output logic              ser_dout,
  output logic              ser_dout_en,
  output logic [ADDR_W-1:0] chan_sel,
  output logic              addr_oor,
  output logic              sampling,
  output logic              busy
);
  localparam int IDX_SYS = 0;
  localparam int IDX_IO  = 1;
  localparam int IDX_ADR = 2;
  localparam int IDX_CS  = 3;

  logic [3:0] raw, lvl;
  logic [1:0] clk_prev;
  logic sys_rise, sys_fall, io_rise, io_fall;
  logic cs_rec, sel_fall, sel_rise, sel_active;
  logic hold_pulse, conv_done, out_bit;
  logic [DATA_W-1:0] conv_result, conv_held;

  assign raw = {sel_n, ser_addr, io_clk, sys_clk};

  adc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1000)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(raw), .q(lvl)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) clk_prev <= 2'b00;
    else        clk_prev <= {lvl[IDX_IO], lvl[IDX_SYS]};
  end

  assign sys_rise =  lvl[IDX_SYS] & ~clk_prev[0];
  assign sys_fall = ~lvl[IDX_SYS] &  clk_prev[0];
  assign io_rise  =  lvl[IDX_IO]  & ~clk_prev[1];
  assign io_fall  = ~lvl[IDX_IO]  &  clk_prev[1];

  adc_cs_qual u_qual (
    .clk(clk), .rst_n(rst_n), .cs_lvl(lvl[IDX_CS]),
    .sys_rise(sys_rise), .sys_fall(sys_fall),
    .cs_rec(cs_rec), .sel_fall(sel_fall), .sel_rise(sel_rise)
  );

  assign sel_active = ~cs_rec;

  adc_conv #(.DATA_W(DATA_W), .CONV_CYCLES(CONV_CYCLES)) u_conv (
    .clk(clk), .rst_n(rst_n), .start(hold_pulse), .abort(sel_fall),
    .sys_rise(sys_rise), .sample_in(sample_in), .busy(busy),
    .done(conv_done), .held(conv_held), .result(conv_result)
  );

  adc_xfer #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .NUM_CH(NUM_CH)) u_xfer (
    .clk(clk), .rst_n(rst_n), .active(sel_active),
    .sel_fall(sel_fall), .sel_rise(sel_rise),
    .io_rise(io_rise), .io_fall(io_fall), .addr_bit(lvl[IDX_ADR]),
    .result(conv_result), .held(conv_held), .conv_done(conv_done),
    .out_bit(out_bit), .chan_sel(chan_sel), .addr_oor(addr_oor),
    .sampling(sampling), .hold_pulse(hold_pulse)
  );

  assign ser_dout_en = sel_active;
  assign ser_dout    = sel_active & out_bit;
endmodule

// File: rtl/adc_serial_seq_chk.sv
module adc_serial_seq_chk #(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ser_dout,
  input logic              ser_dout_en,
  input logic              busy,
  input logic              sampling,
  input logic              addr_oor,
  input logic [ADDR_W-1:0] chan_sel,
  input logic [DATA_W-1:0] conv_result,
  input logic              sys_fall
);
  // R1: a select change is only accepted on a conversion-clock fall
  a_r1_change_on_sys_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout_en) |-> $past(sys_fall));

  // R2: nothing moves while deselected
  a_r2_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !ser_dout_en |=> ($stable(chan_sel) && !sampling));

  // R3: MSB of stored result on the line at select
  a_r3_msb_on_select: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ser_dout_en) |-> (ser_dout == conv_result[DATA_W-1]));

  // R6: sampling ending inside an exchange hands over to conversion
  a_r6_sampling_to_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(sampling) && ser_dout_en) |-> busy);

  // R7: a conversion only begins out of the sample phase
  a_r7_start_from_sampling: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(sampling));

  // R7: the stored result only changes as a conversion ends
  a_r7_result_on_completion: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(conv_result) |-> $fell(busy));

  // R10: an out-of-range number selects channel 0
  a_r10_oor_zero_chan: assert property (@(posedge clk) disable iff (!rst_n)
    addr_oor |-> (chan_sel == '0));
endmodule

bind adc_serial_seq adc_serial_seq_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .ser_dout(ser_dout), .ser_dout_en(ser_dout_en),
  .busy(busy), .sampling(sampling), .addr_oor(addr_oor), .chan_sel(chan_sel),
  .conv_result(conv_result), .sys_fall(sys_fall)
);

// File: tb/adc_serial_seq_bench.sv
module adc_serial_seq_bench;
  localparam int CONV = 36;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_n = 1'b1;
  logic ser_addr = 1'b0;
  logic io_clk = 1'b0;
  logic sys_clk = 1'b0;
  logic [7:0] sample_in = 8'h00;
  logic ser_dout, ser_dout_en, addr_oor, sampling, busy;
  logic [4:0] chan_sel;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;
  logic [7:0] rd_byte;

  always #4 clk = ~clk;

  initial begin
    forever begin
      repeat (5) @(negedge clk);
      sys_clk = ~sys_clk;
    end
  end

  adc_serial_seq u_adc_serial_seq (
    .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .ser_addr(ser_addr),
    .io_clk(io_clk), .sys_clk(sys_clk), .sample_in(sample_in),
    .ser_dout(ser_dout), .ser_dout_en(ser_dout_en), .chan_sel(chan_sel),
    .addr_oor(addr_oor), .sampling(sampling), .busy(busy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // behavioural reference: inputs seen two core cycles late, events on edges
  int hc1, hc2, hc3, ha1, ha2, ha3, hi1, hi2, hi3, hs1, hs2, hs3;
  int m_rec, m_prog, m_bit, m_addr, m_sh, m_chan, m_oor, m_samp;
  int m_busy, m_cnt, m_held, m_res;

  always @(posedge clk) begin : ref_model
    int cs_l, sr, sf, ir, ifl, act, sel_f, sel_r, st, dn, new_rec, old_res, old_held;
    if (!rst_n) begin
      hc1 = 1; hc2 = 1; hc3 = 1;
      ha1 = 0; ha2 = 0; ha3 = 0; hi1 = 0; hi2 = 0; hi3 = 0; hs1 = 0; hs2 = 0; hs3 = 0;
      m_rec = 1; m_prog = 0; m_bit = 0; m_addr = 0; m_sh = 0; m_chan = 0;
      m_oor = 0; m_samp = 0; m_busy = 0; m_cnt = 0; m_held = 0; m_res = 0;
    end else begin
      cs_l = hc2;
      sr = (hs2 == 1 && hs3 == 0);
      sf = (hs2 == 0 && hs3 == 1);
      ir = (hi2 == 1 && hi3 == 0);
      ifl = (hi2 == 0 && hi3 == 1);
      act = (m_rec == 0);
      sel_f = 0; sel_r = 0; new_rec = m_rec;
      if (cs_l == m_rec) m_prog = 0;
      else if (m_prog == 2 && sf) begin
        new_rec = cs_l; sel_f = (cs_l == 0); sel_r = (cs_l == 1); m_prog = 0;
      end else if (sr) m_prog = (m_prog == 0) ? 1 : 2;
      st = act && !sel_f && !sel_r && ifl && (m_bit == 7);
      dn = m_busy && sr && (m_cnt == CONV - 1) && !st && !sel_f;
      old_res = m_res; old_held = m_held;
      if (sel_f) begin m_bit = 0; m_sh = old_res; m_samp = 0; end
      else if (sel_r) begin m_bit = 0; m_samp = 0; end
      else if (act) begin
        if (ir && m_bit < 5) m_addr = ((m_addr << 1) | ha2) & 31;
        if (ifl) begin
          if (m_bit == 7) begin m_bit = 0; m_samp = 0; m_sh = old_res; end
          else begin
            if (m_bit == 4) begin
              m_samp = 1;
              if (m_addr < 19) begin m_chan = m_addr; m_oor = 0; end
              else begin m_chan = 0; m_oor = 1; end
            end
            m_bit = m_bit + 1;
            m_sh = (m_sh << 1) & 255;
          end
        end else if (dn && m_bit == 0) m_sh = old_held;
      end
      if (st) begin m_held = sample_in; m_cnt = 0; m_busy = 1; end
      else if (sel_f) m_busy = 0;
      else if (m_busy && sr) begin
        if (m_cnt == CONV - 1) begin m_busy = 0; m_res = old_held; end
        else m_cnt = m_cnt + 1;
      end
      m_rec = new_rec;
      hc3 = hc2; hc2 = hc1; hc1 = sel_n;
      ha3 = ha2; ha2 = ha1; ha1 = ser_addr;
      hi3 = hi2; hi2 = hi1; hi1 = io_clk;
      hs3 = hs2; hs2 = hs1; hs1 = sys_clk;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(ser_dout_en == (m_rec == 0), "R1 model dout_en", ser_dout_en, (m_rec == 0));
      chk(ser_dout == ((m_rec == 0) ? ((m_sh >> 7) & 1) : 0), "R5 model dout",
          ser_dout, (m_rec == 0) ? ((m_sh >> 7) & 1) : 0);
      chk(chan_sel == m_chan, "R4 model chan_sel", chan_sel, m_chan);
      chk(addr_oor == m_oor, "R10 model addr_oor", addr_oor, m_oor);
      chk(sampling == m_samp, "R6 model sampling", sampling, m_samp);
      chk(busy == m_busy, "R7 model busy", busy, m_busy);
    end
  end

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sel(input logic v);
    sel_n = v;
    wait_cyc(40);
  endtask

  task automatic exchange(input logic [4:0] a, input logic [7:0] smp);
    sample_in = smp;
    rd_byte = '0;
    rd_byte[7] = ser_dout;
    for (int i = 0; i < 8; i++) begin
      ser_addr = (i < 5) ? a[4-i] : 1'b0;
      wait_cyc(6);
      io_clk = 1'b1;
      wait_cyc(6);
      io_clk = 1'b0;
      wait_cyc(6);
      if (i < 7) rd_byte[6-i] = ser_dout;
      if (i == 5) chk(sampling == 1'b1, "R6 sampling after fall 6", sampling, 1);
    end
    chk(sampling == 1'b0, "R6 sampling after fall 8", sampling, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : stim
    wait_cyc(5);
    rst_n = 1'b1;
    wait_cyc(2);
    chk(ser_dout_en == 0 && ser_dout == 0, "R12 reset outputs off", ser_dout_en, 0);
    chk(busy == 0 && sampling == 0, "R12 reset busy/sampling", {busy, sampling}, 0);
    chk(chan_sel == 0 && addr_oor == 0, "R12 reset channel", chan_sel, 0);

    set_sel(1'b0);
    chk(ser_dout_en == 1, "R1 select recognised", ser_dout_en, 1);
    chk(ser_dout == 0, "R3 MSB of reset result", ser_dout, 0);

    exchange(5'd5, 8'hA5);
    chk(rd_byte == 8'h00, "R5 first read", rd_byte, 8'h00);
    chk(chan_sel == 5 && addr_oor == 0, "R4 channel 5", chan_sel, 5);
    chk(busy == 1, "R7 busy after hold", busy, 1);
    wait_cyc(400);
    chk(busy == 0, "R7 conversion ends", busy, 0);
    chk(ser_dout == 1, "R11 new MSB shown", ser_dout, 1);

    exchange(5'd18, 8'h3C);
    chk(rd_byte == 8'hA5, "R5 read A5", rd_byte, 8'hA5);
    chk(chan_sel == 18 && addr_oor == 0, "R10 top valid channel", chan_sel, 18);
    chk(ser_dout == 1, "R11 stored MSB after hold", ser_dout, 1);

    exchange(5'd25, 8'hC3);
    chk(rd_byte == 8'hA5, "R8 restart reads previous", rd_byte, 8'hA5);
    chk(addr_oor == 1 && chan_sel == 0, "R10 out of range", {addr_oor, chan_sel}, 6'h20);
    chk(busy == 1, "R8 busy after restart", busy, 1);
    wait_cyc(400);

    exchange(5'd2, 8'h11);
    chk(rd_byte == 8'hC3, "R8 abandoned value skipped", rd_byte, 8'hC3);

    set_sel(1'b1);
    chk(ser_dout_en == 0 && ser_dout == 0, "R2 line off", {ser_dout_en, ser_dout}, 0);
    chk(busy == 1, "R9 conversion runs while deselected", busy, 1);
    ser_addr = 1'b1;
    for (int k = 0; k < 3; k++) begin
      io_clk = 1'b1; wait_cyc(6);
      io_clk = 1'b0; wait_cyc(6);
    end
    chk(chan_sel == 2 && sampling == 0, "R2 clocks ignored", chan_sel, 2);
    set_sel(1'b0);
    chk(busy == 0, "R9 abort on reselect", busy, 0);
    chk(ser_dout == 1, "R3 MSB of C3 at select", ser_dout, 1);
    wait_cyc(400);
    chk(busy == 0, "R9 stays idle", busy, 0);
    exchange(5'd7, 8'h5A);
    chk(rd_byte == 8'hC3, "R9 result kept", rd_byte, 8'hC3);
    chk(chan_sel == 7, "R4 channel 7", chan_sel, 7);

    sel_n = 1'b1;
    wait_cyc(3);
    sel_n = 1'b0;
    begin
      bit held_on = 1'b1;
      for (int k = 0; k < 30; k++) begin
        wait_cyc(1);
        if (!ser_dout_en) held_on = 1'b0;
      end
      chk(held_on, "R1 short pulse filtered", held_on, 1);
    end
    sel_n = 1'b1;
    wait_cyc(4);
    chk(ser_dout_en == 1, "R1 not yet recognised", ser_dout_en, 1);
    wait_cyc(40);
    chk(ser_dout_en == 0, "R1 deselect recognised", ser_dout_en, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule